// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the drive-side strobes for a single programmed-I/O transfer on an IDE channel. A transfer runs through three phases in a fixed order. First comes address setup, where chip-select and the register address are driven. Next is the active phase, where the read or write strobe is asserted. Last is recovery, which keeps the channel busy until the drive can accept another access. The block pulses done in the last recovery clock and returns to idle on the following clock.

The length of each phase comes from timing registers that sit outside the block and arrive as port values. The two master/slave positions of the first channel (drives 0 and 1) each have their own address-timing and data-timing register. Drives 2 and 3 share a single pair. An access to the drive's command block takes its active and recovery counts from a separate command-timing register. All phase lengths are taken when the request is accepted and stay fixed until that transfer completes.

Top module: `pio_strobe_gen`

## Requirements
- R1: The setup phase length is decoded from bits [7:6] of the selected address-timing register: 2'b00 gives 4 clocks, 2'b10 gives 3, 2'b01 gives 2 and 2'b11 gives 5.
- R2: The data-timing register carries the active count in bits [7:4] and the recovery count in bits [3:0]. A nibble of 0 stands for 16 clocks.
- R3: A programmed active count of 1 runs as 2 clocks.
- R4: When the programmed active count is greater than 3 (a nibble of 0, meaning 16, counts as greater than 3) and the recovery count is 1, recovery runs as 2 clocks.
- R5: When `rev_i` is greater than 1, recovery lasts one clock longer than the count that R2 and R4 give.
- R6: Drive 0 uses `at0_i`/`dt0_i` and drive 1 uses `at1_i`/`dt1_i`. Drives 2 and 3 both use `at23_i`/`dt23_i`.
- R7: A command-block access (`req_cmd_i`=1) keeps the drive's setup field but takes its active and recovery counts from `cmd_tim_i`. A value of 0 gives 16/16, the slowest timing.
- R8: A request is accepted only while idle. A request raised while busy does not change the running transfer, the drive index or address on the outputs, or the transfers that follow.
- R9: `done_o` is high for exactly one clock, the last recovery clock, and `busy_o` is low on the next clock.
- R10: `cs_o` is high throughout setup and active and low in recovery. `rd_stb_o` (for reads) or `wr_stb_o` (for writes) is high only during active, and never both. `drive_o` and `addr_o` hold the request's values while `cs_o` is high.
- R11: Bits [5:0] of the address-timing register have no effect on any phase length.
- R12: After reset the block is idle, with `cs_o`, both strobes, `busy_o` and `done_o` low.
- R13: A change to the timing inputs after a request is accepted does not alter that transfer's phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Transfer request, taken only when idle |
| req_drive_i | input | 2 | Drive index 0..3 |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cmd_i | input | 1 | 1 = command-block access, uses command timing |
| req_addr_i | input | 3 | Drive register address |
| rev_i | input | 2 | Controller revision; above 1 lengthens recovery |
| at0_i | input | 8 | Address-timing register, drive 0 |
| dt0_i | input | 8 | Data-timing register, drive 0 |
| at1_i | input | 8 | Address-timing register, drive 1 |
| dt1_i | input | 8 | Data-timing register, drive 1 |
| at23_i | input | 8 | Shared address-timing register, drives 2 and 3 |
| dt23_i | input | 8 | Shared data-timing register, drives 2 and 3 |
| cmd_tim_i | input | 8 | Command-block active/recovery register |
| cs_o | output | 1 | Chip-select, setup and active phases |
| addr_o | output | 3 | Latched register address |
| drive_o | output | 2 | Latched drive index |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last recovery clock |

## Verification
A wrong decode or an off-by-one in the phase counter appears at the ports as a run of `cs_o`, strobe or recovery clocks of the wrong length. This is visible by the end of the affected phase in the first transfer that uses that encoding. A bad register selection or a lost latch shows up as another drive's lengths, or as `drive_o` changing while `cs_o` is high, within the same transfer. A phase state stuck at the wrong value either shows both strobes, leaves `done_o` high for more than one clock, or never reaches `done_o`. The last of these stalls the queue of expected transfers.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;
  localparam int CNT_W = 5;  // holds lengths up to 17

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } lens_t;

  // Two-bit setup code to clocks (nonmonotonic encoding).
  function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(4);
      2'b10:   return CNT_W'(3);
      2'b01:   return CNT_W'(2);
      default: return CNT_W'(5);
    endcase
  endfunction

  // Nibble to clocks, zero meaning sixteen.
  function automatic logic [CNT_W-1:0] nib_clocks(input logic [3:0] nib);
    return (nib == 4'd0) ? CNT_W'(16) : CNT_W'(nib);
  endfunction

  function automatic logic [CNT_W-1:0] active_clocks(input logic [3:0] nib);
    logic [CNT_W-1:0] n;
    n = nib_clocks(nib);
    return (n == CNT_W'(1)) ? CNT_W'(2) : n;
  endfunction

  function automatic logic [CNT_W-1:0] recov_clocks(input logic [3:0] act_nib,
                                                     input logic [3:0] rec_nib,
                                                     input logic       extra);
    logic [CNT_W-1:0] r;
    r = nib_clocks(rec_nib);
    if (nib_clocks(act_nib) > CNT_W'(3) && r == CNT_W'(1)) r = CNT_W'(2);
    return extra ? r + CNT_W'(1) : r;
  endfunction
endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
  import pio_strobe_pkg::*;
#(
  parameter int TREG_W = 8,
  parameter int REV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        drive,
  input  logic              cmd_acc,
  input  logic [REV_W-1:0]  rev,
  input  logic [TREG_W-1:0] at0,
  input  logic [TREG_W-1:0] dt0,
  input  logic [TREG_W-1:0] at1,
  input  logic [TREG_W-1:0] dt1,
  input  logic [TREG_W-1:0] at23,
  input  logic [TREG_W-1:0] dt23,
  input  logic [TREG_W-1:0] cmd_tim,
  output lens_t             lens
);
  localparam int NIB = TREG_W / 2;

  logic [TREG_W-1:0] at_sel, dt_sel, dt_use;
  logic [NIB-1:0]    act_nib, rec_nib;
  logic              rev_extra;

  // Drives 2 and 3 share one pair: only drive[1] and drive[0] on the first channel matter.
  always_comb begin
    case (drive)
      2'd0:    begin at_sel = at0;  dt_sel = dt0;  end
      2'd1:    begin at_sel = at1;  dt_sel = dt1;  end
      default: begin at_sel = at23; dt_sel = dt23; end
    endcase
  end

  assign dt_use    = cmd_acc ? cmd_tim : dt_sel;
  assign act_nib   = dt_use[TREG_W-1:NIB];
  assign rec_nib   = dt_use[NIB-1:0];
  assign rev_extra = (rev > REV_W'(1));

  always_comb begin
    lens.setup  = setup_clocks(at_sel[TREG_W-1:TREG_W-2]);
    lens.active = active_clocks(act_nib[3:0]);
    lens.recov  = recov_clocks(act_nib[3:0], rec_nib[3:0], rev_extra);
  end

  p_setup_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lens.setup >= CNT_W'(2) && lens.setup <= CNT_W'(5));
  p_active_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lens.active >= CNT_W'(2) && lens.active <= CNT_W'(16));
  p_recov_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lens.recov >= CNT_W'(1) && lens.recov <= CNT_W'(17));
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_strobe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  lens_t  lens,
  output phase_t phase,
  output logic   last
);
  lens_t            held;
  logic [CNT_W-1:0] cnt;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      held  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          held  <= lens;
          phase <= PH_SETUP;
          cnt   <= lens.setup - CNT_W'(1);
        end
        PH_SETUP: if (last) begin
          phase <= PH_ACTIVE;
          cnt   <= held.active - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        PH_ACTIVE: if (last) begin
          phase <= PH_RECOV;
          cnt   <= held.recov - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        default: if (last) phase <= PH_IDLE;
          else cnt <= cnt - CNT_W'(1);
      endcase
    end
  end

  p_cnt_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(16));
  p_idle_counter_r12: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IDLE |-> last);
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int TREG_W = 8,
  parameter int REV_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        req_drive_i,
  input  logic              req_write_i,
  input  logic              req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [REV_W-1:0]  rev_i,
  input  logic [TREG_W-1:0] at0_i,
  input  logic [TREG_W-1:0] dt0_i,
  input  logic [TREG_W-1:0] at1_i,
  input  logic [TREG_W-1:0] dt1_i,
  input  logic [TREG_W-1:0] at23_i,
  input  logic [TREG_W-1:0] dt23_i,
  input  logic [TREG_W-1:0] cmd_tim_i,
  output logic              cs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        drive_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic              busy_o,
  output logic              done_o
);
  lens_t  lens;
  phase_t phase;
  logic   last, start, is_write;

  assign start = req_i && (phase == PH_IDLE);

  pio_timing_sel #(.TREG_W(TREG_W), .REV_W(REV_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .drive(req_drive_i), .cmd_acc(req_cmd_i),
    .rev(rev_i), .at0(at0_i), .dt0(dt0_i), .at1(at1_i), .dt1(dt1_i),
    .at23(at23_i), .dt23(dt23_i), .cmd_tim(cmd_tim_i), .lens(lens));

  pio_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .lens(lens),
    .phase(phase), .last(last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o   <= '0;
      drive_o  <= '0;
      is_write <= 1'b0;
    end else if (start) begin
      addr_o   <= req_addr_i;
      drive_o  <= req_drive_i;
      is_write <= req_write_i;
    end
  end

  assign busy_o   = (phase != PH_IDLE);
  assign cs_o     = (phase == PH_SETUP) || (phase == PH_ACTIVE);
  assign rd_stb_o = (phase == PH_ACTIVE) && !is_write;
  assign wr_stb_o = (phase == PH_ACTIVE) && is_write;
  assign done_o   = (phase == PH_RECOV) && last;

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb_o && wr_stb_o));
  p_strobe_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o || wr_stb_o) |-> cs_o);
  p_setup_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb_o || wr_stb_o) |-> $past(cs_o));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  p_target_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(drive_o) && $stable(addr_o));
endmodule

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0, req_write_i = 1'b0, req_cmd_i = 1'b0;
  logic [1:0] req_drive_i = '0, rev_i = 2'd1;
  logic [2:0] req_addr_i = '0;
  logic [7:0] at0_i = '0, dt0_i = '0, at1_i = '0, dt1_i = '0;
  logic [7:0] at23_i = '0, dt23_i = '0, cmd_tim_i = '0;
  logic       cs_o, rd_stb_o, wr_stb_o, busy_o, done_o;
  logic [2:0] addr_o;
  logic [1:0] drive_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pio_strobe_gen u_dut (.*);

  typedef struct {
    int drv; int wr; int addr; int s; int a; int r; string tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nib16(input int v);
    return (v == 0) ? 16 : v;
  endfunction

  task automatic issue(input int drv, input int wr, input int cmd, input int addr, input string tag);
    exp_t e;
    int at, dt, sc;
    while (busy_o) @(negedge clk);
    at = (drv == 0) ? at0_i : (drv == 1) ? at1_i : at23_i;
    dt = cmd ? cmd_tim_i : (drv == 0) ? dt0_i : (drv == 1) ? dt1_i : dt23_i;
    sc = (at >> 6) & 3;
    e.s = (sc == 0) ? 4 : (sc == 2) ? 3 : (sc == 1) ? 2 : 5;
    e.a = nib16(dt >> 4);
    if (e.a == 1) e.a = 2;
    e.r = nib16(dt & 15);
    if (nib16(dt >> 4) > 3 && e.r == 1) e.r = 2;
    if (rev_i > 1) e.r = e.r + 1;
    e.drv = drv; e.wr = wr; e.addr = addr; e.tag = tag;
    q.push_back(e);
    req_i = 1'b1; req_drive_i = 2'(drv); req_write_i = wr[0];
    req_cmd_i = cmd[0]; req_addr_i = 3'(addr);
    @(negedge clk);
    req_i = 1'b0; req_cmd_i = 1'b0;
  endtask

  // Monitor: measure phase lengths at the ports, compare on done.
  int  s_cnt = 0, a_cnt = 0, r_cnt = 0, seen_wr = 0, post_done = 0;
  bit  tgt_ok = 1;
  always @(negedge clk) if (rst_n) begin
    if (post_done) begin
      check(!busy_o && !done_o, "R9 busy clears after done", busy_o, 0);
      post_done = 0;
    end
    if (cs_o && !rd_stb_o && !wr_stb_o) s_cnt++;
    if (rd_stb_o || wr_stb_o) begin a_cnt++; seen_wr = wr_stb_o; end
    if (rd_stb_o && wr_stb_o) tgt_ok = 0;
    if (busy_o && !cs_o) r_cnt++;
    if (cs_o && q.size() > 0)
      if (drive_o != 2'(q[0].drv) || addr_o != 3'(q[0].addr)) tgt_ok = 0;
    if (done_o) begin
      if (q.size() == 0) check(0, "R8 unexpected transfer", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(s_cnt == e.s, {e.tag, " setup"}, s_cnt, e.s);
        check(a_cnt == e.a, {e.tag, " active"}, a_cnt, e.a);
        check(r_cnt == e.r, {e.tag, " recovery"}, r_cnt, e.r);
        check(seen_wr == e.wr, {e.tag, " R10 strobe direction"}, seen_wr, e.wr);
        check(tgt_ok, {e.tag, " R10 drive/addr while cs"}, 0, 1);
      end
      s_cnt = 0; a_cnt = 0; r_cnt = 0; tgt_ok = 1; post_done = 1;
    end
  end

  task automatic drain;
    while (q.size() > 0 || busy_o || post_done) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cs_o && !rd_stb_o && !wr_stb_o && !busy_o && !done_o,
          "R12 reset idle", {cs_o, rd_stb_o, wr_stb_o, busy_o, done_o}, 0);

    // R1 R2 basic decode per drive
    at0_i = 8'h00; dt0_i = 8'h35;
    issue(0, 0, 0, 3, "R1 R2 drive0 read");
    at1_i = 8'h80; dt1_i = 8'h00;
    issue(1, 1, 0, 5, "R2 R6 drive1 write zero=16");
    at23_i = 8'h40; dt23_i = 8'h12;
    issue(2, 0, 0, 1, "R3 R6 drive2 active1");
    issue(3, 1, 0, 7, "R6 drive3 shares pair");
    // R4 recovery stretch
    at0_i = 8'h80; dt0_i = 8'h41;
    issue(0, 1, 0, 2, "R4 active4 rec1");
    dt0_i = 8'h31;
    issue(0, 0, 0, 2, "R4 active3 rec1 unchanged");
    dt0_i = 8'h01;
    issue(0, 0, 0, 4, "R4 active16 rec1");
    drain();
    // R5 revision
    rev_i = 2'd2; dt0_i = 8'h35;
    issue(0, 0, 0, 6, "R5 rev2 plus one");
    dt0_i = 8'h00;
    issue(0, 1, 0, 6, "R5 rev2 max 17");
    dt0_i = 8'h41;
    issue(0, 0, 0, 6, "R4 R5 rev2 stretched");
    drain();
    rev_i = 2'd1;
    // R11 low bits ignored, setup code 11
    at0_i = 8'hC0; dt0_i = 8'h23;
    issue(0, 0, 0, 1, "R1 setup5");
    at0_i = 8'hFF;
    issue(0, 0, 0, 1, "R11 low bits ignored");
    at1_i = 8'h7F; dt1_i = 8'h23;
    issue(1, 1, 0, 1, "R11 code01 with low bits");
    // R7 command timing
    cmd_tim_i = 8'h00; at0_i = 8'h80;
    issue(0, 1, 1, 7, "R7 cmd zero slowest");
    cmd_tim_i = 8'h24;
    issue(2, 0, 1, 7, "R7 cmd programmed");
    drain();
    // R8 request while busy ignored; R13 latched timing
    at0_i = 8'h00; dt0_i = 8'h22;
    issue(0, 0, 0, 3, "R8 R13 victim");
    req_i = 1'b1; req_drive_i = 2'd3; req_addr_i = 3'd6; req_write_i = 1'b1;
    dt0_i = 8'h99; at0_i = 8'hC0;
    @(negedge clk);
    check(drive_o == 2'd0 && addr_o == 3'd3, "R8 target unchanged", {drive_o, addr_o}, 3);
    req_i = 1'b0;
    drain();
    check(q.size() == 0 && !busy_o, "R8 no extra transfer", busy_o, 0);
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule